// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Bus Controller

This block connects a single-clock request port to an external asynchronous static RAM with an 18-bit address and an 8-bit shared data bus. A client presents one read or one write at a time with a valid/ready handshake. The controller then drives the active-low chip-select, read-strobe and write-strobe lines and the enable of its own data drivers. Read data comes back with a one-cycle valid pulse.

Strobe widths are counted in clock cycles. Each count comes from a nanosecond minimum and the clock period, rounded up to a whole cycle. The read-strobe line stays high for the whole of every write, so the short write-strobe pulse that applies in that case is enough. The controller turns on its data drivers only after the memory has had at least one cycle to release the bus. After a read it waits out a turnaround gap before it starts the next access.

Sequencer states: `ST_IDLE`, `ST_RD_ACC`, `ST_RD_TURN`, `ST_WR_SETUP`, `ST_WR_PULSE`, `ST_WR_HOLD`.

Transitions:
- IDLE to RD_ACC: a read request is accepted.
- IDLE to WR_SETUP: a write request is accepted.
- RD_ACC to RD_TURN: the last access cycle ends and the data is captured.
- RD_TURN to IDLE: the turnaround gap has elapsed.
- WR_SETUP to WR_PULSE: after one cycle.
- WR_PULSE to WR_HOLD: after the last pulse cycle.
- WR_HOLD to IDLE: after one cycle.

Top module: `sram_bridge`

## Requirements
- R1: While reset is low, and right after it is released, the chip-select, read-strobe and write-strobe outputs are high, the data drivers are off, `rsp_valid` is low and `req_ready` is high.
- R2: A request is accepted only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low for RD_CYC+TURN_CYC cycles after a read is accepted and for WE_CYC+2 cycles after a write is accepted. A request raised while `req_ready` is low has no effect.
- R3: A read holds chip-select and read-strobe low together for exactly RD_CYC cycles. The write-strobe stays high for the whole read.
- R4: Read data is sampled from `mem_dq_in` at the clock edge that ends the last read-strobe cycle. It is returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle, in the cycle that follows that edge.
- R5: The write-strobe is low only while chip-select is low. It stays low for exactly WE_CYC cycles, and the read-strobe stays high for the whole write. Write-strobe low with chip-select high is never driven.
- R6: `mem_dq_oe` is never high while the read-strobe is low. It rises only when the read-strobe was high in the previous cycle.
- R7: The write data and `mem_dq_oe` stay unchanged for one cycle after the write-strobe rises. The drivers turn off in the cycle after that.
- R8: After a read-strobe period ends, chip-select and read-strobe are both high for at least one turnaround cycle before another access starts.
- R9: `mem_addr` does not change while chip-select stays low.
- R10: A read returns the byte most recently written to the same address. This includes the lowest address (0x00000) and the highest address (0x3FFFF).
- R11: The cycle counts are the nanosecond minimums divided by the clock period, rounded up. The defaults are a 5 ns clock, 10 ns read access, 8 ns write pulse and 4 ns turnaround, which give RD_CYC=2, WE_CYC=2 and TURN_CYC=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 18 | Address to memory |
| mem_ce_n | output | 1 | Chip-select, active low |
| mem_oe_n | output | 1 | Read-strobe, active low |
| mem_we_n | output | 1 | Write-strobe, active low |
| mem_dq_out | output | 8 | Data the controller drives onto the shared bus |
| mem_dq_oe | output | 1 | Enable of the controller's data drivers |
| mem_dq_in | input | 8 | Data sampled from the shared bus |

## Verification
The bench's memory model only presents correct data once the strobes have been low for a full access time, and it presents the inverted byte before that. A controller that samples one cycle early therefore returns wrong data instead of passing by luck.

The model also checks the following:
- Pulse widths are measured when each strobe rises, so an off-by-one wait count shows up as a width error.
- Driver enables that overlap a read-strobe period, or its turnaround cycle, are reported as contention.
- Data that is dropped at the moment the write-strobe rises is reported as a hold error.

The bench writes the two end addresses and then reads them back. It also raises requests while the controller is busy and then shows, by a read-back, that they stored nothing. A sequencer that dropped the turnaround gap, or that accepted a request while busy, would fail the per-cycle ready comparison.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_state_e;

    // Whole cycles covering a nanosecond-scale minimum, never less than one.
    function automatic int cyc_of(input int min_ps, input int clk_ps);
        int c;
        c = (min_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/sram_wait_ctr.sv
module sram_wait_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt != CNT_TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cap,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_data
);

    // Address and write byte are latched once per access, so both stay
    // stable for the whole time chip-select is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
        end else if (load) begin
            mem_addr <= req_addr;
            dq_out   <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (cap) begin
            rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_bridge_pkg::*;
#(
    parameter int RD_CYC   = 2,
    parameter int WE_CYC   = 2,
    parameter int TURN_CYC = 1,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    output logic             req_ready,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             load,
    output logic             cap,
    output logic             rsp_valid,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);

    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LAST   = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

    seq_state_e state, state_nx;
    logic       last;

    // State register; the response strobe is registered beside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b0;
        end else begin
            state     <= state_nx;
            rsp_valid <= cap;
        end
    end

    // Next state.
    always_comb begin
        last     = 1'b0;
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) state_nx = req_write ? ST_WR_SETUP : ST_RD_ACC;
            end
            ST_RD_ACC: begin
                last = (cnt == RD_LAST);
                if (last) state_nx = ST_RD_TURN;
            end
            ST_RD_TURN: begin
                last = (cnt == TURN_LAST);
                if (last) state_nx = ST_IDLE;
            end
            ST_WR_SETUP: begin
                last     = 1'b1;
                state_nx = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                last = (cnt == WE_LAST);
                if (last) state_nx = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                last     = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign cnt_clr = (state_nx != state);

    // Outputs decoded from the current state.
    always_comb begin
        req_ready = 1'b0;
        load      = 1'b0;
        cap       = 1'b0;
        ce_n      = 1'b1;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        dq_oe     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                load      = req_valid;
            end
            ST_RD_ACC: begin
                ce_n = 1'b0;
                oe_n = 1'b0;
                cap  = last;
            end
            ST_RD_TURN: begin
            end
            ST_WR_SETUP: begin
                ce_n = 1'b0;
            end
            ST_WR_PULSE: begin
                ce_n  = 1'b0;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                ce_n  = 1'b0;
                dq_oe = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int CLK_PS    = 5000,
    parameter int T_RD_PS   = 10000,
    parameter int T_WE_PS   = 8000,
    parameter int T_TURN_PS = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_CYC   = cyc_of(T_RD_PS, CLK_PS);
    localparam int WE_CYC   = cyc_of(T_WE_PS, CLK_PS);
    localparam int TURN_CYC = cyc_of(T_TURN_PS, CLK_PS);
    localparam int MAX_CYC  = max3(RD_CYC, WE_CYC, TURN_CYC);
    localparam int CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             load;
    logic             cap;

    sram_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    sram_seq #(
        .RD_CYC   (RD_CYC),
        .WE_CYC   (WE_CYC),
        .TURN_CYC (TURN_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .load      (load),
        .cap       (cap),
        .rsp_valid (rsp_valid),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cap       (cap),
        .dq_in     (mem_dq_in),
        .mem_addr  (mem_addr),
        .dq_out    (mem_dq_out),
        .rd_data   (rsp_rdata)
    );

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    a_r2_busy_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    a_r3_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r5_we_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    a_r6_no_drive_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r6_drive_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    a_r7_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    a_r7_release_next: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> !mem_dq_oe);

    a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    a_r8_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |=> mem_ce_n);

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_bridge sram_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_bridge_tb.sv
`timescale 1ns/1ps
module sram_bridge_tb;

    // R11: 10 ns / 5 ns = 2, 8 ns / 5 ns rounds up to 2, 4 ns / 5 ns rounds up to 1
    localparam int RD_EXP   = 2;
    localparam int WE_EXP   = 2;
    localparam int TURN_EXP = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  model_dq = 8'h00;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sram_bridge u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (model_dq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model storage and bench scoreboard, kept apart.
    logic [7:0] mm [int];
    logic [7:0] sb [int];

    function automatic logic [7:0] mget(input int a);
        return mm.exists(a) ? mm[a] : 8'h00;
    endfunction

    function automatic logic [7:0] sget(input int a);
        return sb.exists(a) ? sb[a] : 8'h00;
    endfunction

    // Reference state for the request side.
    int         busy = 0;
    int         rsp_cd = 0;
    logic [7:0] exp_rd = 8'h00;

    // Previous-cycle view of the memory pins.
    logic        p_ce_n = 1'b1, p_oe_n = 1'b1, p_we_n = 1'b1, p_dq_oe = 1'b0, p_rd = 1'b0;
    logic [17:0] p_addr = '0;
    logic [7:0]  p_dq = '0;
    int          rd_run = 0;
    int          we_run = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 strobes idle", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
            chk(!rsp_valid && req_ready, "R1 handshake idle", {rsp_valid, req_ready}, 2'b01);
        end else begin : mon
            logic rd_now;
            // Request-side reference model, compared every cycle.
            chk(req_ready == (busy == 0), "R2 ready", req_ready, busy == 0);
            if (busy > 0) busy--;
            chk(rsp_valid == (rsp_cd == 1), "R4 rsp_valid timing", rsp_valid, rsp_cd == 1);
            if (rsp_cd == 1 && rsp_valid) chk(rsp_rdata == exp_rd, "R10 read data", rsp_rdata, exp_rd);
            if (rsp_cd > 0) rsp_cd--;
            if (req_valid && req_ready) begin
                if (req_write) begin
                    sb[int'(req_addr)] = req_wdata;
                    busy = WE_EXP + 2;
                end else begin
                    exp_rd = sget(int'(req_addr));
                    busy   = RD_EXP + TURN_EXP;
                    rsp_cd = RD_EXP + 1;
                end
            end

            // Pin-level memory model checks.
            rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;
            if (!mem_we_n) begin
                if (!(mem_ce_n == 1'b0 && mem_oe_n == 1'b1))
                    chk(1'b0, "R5 write strobe encoding", {mem_ce_n, mem_oe_n}, 2'b01);
            end
            if (mem_dq_oe && (!mem_oe_n || p_rd))
                chk(1'b0, "R6 bus contention", {mem_oe_n, p_rd}, 2'b10);
            if (mem_dq_oe && !p_dq_oe)
                chk(p_oe_n && !mem_ce_n, "R6 driver start", {p_oe_n, mem_ce_n}, 2'b10);
            if (!mem_ce_n && !p_ce_n)
                chk(mem_addr == p_addr, "R9 address stable", mem_addr, p_addr);
            if (mem_dq_oe && p_dq_oe)
                chk(mem_dq_out == p_dq, "R7 data stable", mem_dq_out, p_dq);

            if (rd_now) begin
                rd_run = (p_rd && mem_addr == p_addr) ? rd_run + 1 : 1;
            end else begin
                if (p_rd) begin
                    chk(rd_run == RD_EXP, "R3 read strobe width", rd_run, RD_EXP);
                    chk(mem_ce_n && mem_oe_n, "R8 turnaround", {mem_ce_n, mem_oe_n}, 2'b11);
                end
                rd_run = 0;
            end

            if (!mem_we_n) begin
                we_run++;
            end else if (!p_we_n) begin
                chk(we_run == WE_EXP, "R5 R11 write pulse width", we_run, WE_EXP);
                chk(mem_dq_oe && mem_dq_out == p_dq, "R7 hold after write", {mem_dq_oe, mem_dq_out}, {1'b1, p_dq});
                mm[int'(p_addr)] = p_dq;
                we_run = 0;
            end

            // Correct data only once the full access time has passed.
            model_dq = (rd_now && rd_run >= RD_EXP) ? mget(int'(mem_addr)) : ~mget(int'(mem_addr));
        end
        p_ce_n  = mem_ce_n;
        p_oe_n  = mem_oe_n;
        p_we_n  = mem_we_n;
        p_dq_oe = mem_dq_oe;
        p_addr  = mem_addr;
        p_dq    = mem_dq_out;
        p_rd    = !mem_ce_n && !mem_oe_n && mem_we_n;
    end

    task automatic do_op(input bit w, input logic [17:0] a, input logic [7:0] d);
        bit acc;
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        do begin
            @(negedge clk);
            acc = req_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        req_valid = 1'b0;
    endtask

    task automatic idle_until_ready();
        do @(negedge clk); while (!req_ready);
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 after release", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);
        @(posedge clk);
        #1;

        // R10: boundary addresses, then read back
        do_op(1'b1, 18'h00000, 8'hA5);
        do_op(1'b1, 18'h3FFFF, 8'h5A);
        do_op(1'b0, 18'h00000, 8'h00);
        do_op(1'b0, 18'h3FFFF, 8'h00);
        do_op(1'b0, 18'h12345, 8'h00); // never written
        idle_until_ready();

        // R2: request raised while busy, withdrawn before ready returns
        do_op(1'b1, 18'h00010, 8'h3C);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00010; req_wdata = 8'hFF;
        @(posedge clk); @(posedge clk); #1;
        req_valid = 1'b0;
        idle_until_ready();
        do_op(1'b0, 18'h00010, 8'h00); // R2: still holds 3C
        idle_until_ready();

        // Back-to-back, valid held: read after read, write after read, read after write
        do_op(1'b0, 18'h3FFFF, 8'h00);
        do_op(1'b0, 18'h00000, 8'h00);
        do_op(1'b1, 18'h00000, 8'hC3);
        do_op(1'b0, 18'h00000, 8'h00);
        idle_until_ready();

        // Random mix on a small address set plus the end addresses
        for (int i = 0; i < 400; i++) begin
            logic [17:0] a;
            case ($urandom_range(0, 3))
                0: a = 18'h3FFFF;
                1: a = 18'h00000;
                default: a = 18'(($urandom_range(0, 15)) << 6);
            endcase
            do_op(1'($urandom_range(0, 1)), a, 8'($urandom));
            if ($urandom_range(0, 3) == 0) idle_until_ready();
        end
        idle_until_ready();
        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule